// File: doc/BRIEF.md
# Clock Ratio Detector and Power Sequencer

This block sequences start-up and shutdown for the digital half of a stereo audio converter. All of its logic runs on a free-running reference clock. It samples the converter's master clock and frame (word-select) clock as asynchronous inputs. The first time the master clock shows activity after reset, the block latches a board strap that chooses master or slave operation. That choice then holds until the next reset.

In master operation the block produces the frame clock itself, dividing the master clock by 256. It begins driving that clock a fixed number of master-clock cycles into initialisation. In slave operation it counts master-clock rising edges between two consecutive frame-clock rising edges. It accepts the count only when the count lies close to one of the supported ratios, and otherwise it tries again on the next frame.

Once the ratio is known, the block enables the reference and keeps the serial output muted for a set number of frames while downstream filters settle. It then releases the mute. A watchdog monitors each clock. If a required clock stalls, the block returns to power-down. When the clocks come back, it runs initialisation again, and in slave operation it measures the ratio again.

Top module: `clkratio_pwrseq`

## Requirements
- R1: After reset, and until the master clock has toggled (in slave operation, until both clocks have toggled), the block stays powered down: mute_o=1, run_o=0, ref_en_o=0, fclk_oe_o=0, ratio_o=0, div_sel_o=0.
- R2: strap_master_i (1 = master) is captured once, on the first detection of master-clock activity after reset. Later changes of the strap have no effect until the next reset, including across power-down and restart.
- R3: In slave operation, the ratio is the number of master-clock rising edges between two consecutive frame-clock rising edges. A count within ±TOL of 256, 384 or 512 is locked as ratio_o code 1, 2 or 3 respectively. div_sel_o is one-hot, with bit 0 for 256, bit 1 for 384 and bit 2 for 512.
- R4: A slave count outside every tolerance window is rejected, ratio_o stays 0 and the reference stays off. The next full frame is measured again.
- R5: In master operation, the frame clock is driven (fclk_oe_o=1) starting at the PRE_CYCLES-th (127th) master-clock rising edge that the block sees after leaving power-down. fclk_o is high for 128 and low for 128 master-clock periods, and ratio_o reads 1.
- R6: ref_en_o asserts together with fclk_oe_o in master operation, or on the cycle after the ratio locks in slave operation.
- R7: mute_o stays 1 for MUTE_FRAMES frame periods after ref_en_o rises. At the end of that interval, mute_o falls and run_o rises.
- R8: mute_level_o is 0 in master operation and 1 in slave operation. Before the strap is captured, it follows the strap.
- R9: A clock with no edge for its timeout (MCLK_TMO or FCLK_TMO reference cycles) is treated as lost. Loss of the master clock, or in slave operation loss of the frame clock, returns all outputs to the R1 power-down values.
- R10: When the required clocks return, initialisation restarts from the start. In slave operation the ratio is measured again, so a changed ratio is picked up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_i | input | 1 | Master clock, sampled asynchronously |
| fclk_i | input | 1 | Frame clock from outside (slave operation) |
| strap_master_i | input | 1 | Operating-mode strap, 1 = master |
| fclk_o | output | 1 | Generated frame clock (master operation) |
| fclk_oe_o | output | 1 | Output enable for fclk_o |
| ratio_o | output | 2 | Ratio code: 0 none, 1 = 256, 2 = 384, 3 = 512 |
| div_sel_o | output | 3 | One-hot divider select for the locked ratio |
| ref_en_o | output | 1 | Reference enable |
| mute_o | output | 1 | Serial output mute |
| mute_level_o | output | 1 | Static level the data pin holds while muted |
| run_o | output | 1 | Initialisation finished, data flowing |

## Verification
The bench builds the block with MUTE_FRAMES=3, TOL=2, MCLK_TMO=16 and FCLK_TMO=1100. With these values a complete master start-up, including the full mute interval, takes under a thousand master-clock periods. A slave lock and settle takes a handful of frames. The narrow tolerance puts the exact window edges in reach: 258 and 510 must lock, 381 must be rejected and 386 must then lock. The frame-clock timeout sits just above the longest half-frame at ratio 512, so the bench can exercise frame-clock loss and re-measurement within the run.

// File: rtl/clkratio_pkg.sv
package clkratio_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_PRE    = 3'd1,
    ST_MEAS   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_RUN    = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    RC_NONE = 2'd0,
    RC_256  = 2'd1,
    RC_384  = 2'd2,
    RC_512  = 2'd3
  } ratio_code_t;

  localparam int unsigned MASTER_DIV    = 256;
  localparam int unsigned LARGEST_RATIO = 512;

  // true when cnt lies within nom +/- tol
  function automatic logic near_nominal(input int unsigned cnt,
                                        input int unsigned nom,
                                        input int unsigned tol);
    return ((cnt + tol) >= nom) && (cnt <= (nom + tol));
  endfunction

  function automatic ratio_code_t classify_count(input int unsigned cnt,
                                                 input int unsigned tol);
    if (near_nominal(cnt, 256, tol)) return RC_256;
    if (near_nominal(cnt, 384, tol)) return RC_384;
    if (near_nominal(cnt, 512, tol)) return RC_512;
    return RC_NONE;
  endfunction

  function automatic logic [2:0] code_to_sel(input ratio_code_t c);
    case (c)
      RC_256:  return 3'b001;
      RC_384:  return 3'b010;
      RC_512:  return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/clk_presence.sv
module clk_presence #(
  parameter int unsigned TMO  = 64,
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic rise_o,
  output logic edge_o,
  output logic alive_o
);
  localparam int unsigned TW = $clog2(TMO + 1);
  localparam logic [TW-1:0] TMO_V = TW'(TMO);

  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic [TW-1:0]   idle_q;
  logic            level;

  assign level = sync_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], raw_i};
      prev_q <= level;
    end
  end

  assign edge_o = level ^ prev_q;
  assign rise_o = level & ~prev_q;

  // watchdog: counts reference cycles since the last edge, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               idle_q <= TMO_V;
    else if (edge_o)          idle_q <= '0;
    else if (idle_q < TMO_V)  idle_q <= idle_q + 1'b1;
  end

  assign alive_o = (idle_q < TMO_V);

  // R9
  edge_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> alive_o);

  // R9
  idle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q <= TMO_V);

endmodule

// File: rtl/ratio_meter.sv
module ratio_meter
  import clkratio_pkg::*;
#(
  parameter int unsigned TOL   = 4,
  parameter int unsigned CNT_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear_i,
  input  logic        mclk_rise_i,
  input  logic        fclk_rise_i,
  output logic        done_o,
  output ratio_code_t code_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic [CNT_W:0]   total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (fclk_rise_i) begin
      armed_q <= 1'b1;
      cnt_q   <= {{(CNT_W-1){1'b0}}, mclk_rise_i};
    end else if (mclk_rise_i && (cnt_q != {CNT_W{1'b1}})) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // rising edges up to and including this cycle
  assign total  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, mclk_rise_i};
  assign done_o = fclk_rise_i & armed_q & ~clear_i;
  assign code_o = classify_count(int'(total), TOL);

  // R4
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fclk_rise_i && !clear_i) |=> (armed_q && cnt_q <= 1));

endmodule

// File: rtl/frame_gen.sv
module frame_gen #(
  parameter int unsigned RATIO = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic mclk_rise_i,
  output logic fclk_o,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(RATIO);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
  localparam logic [CW-1:0] HALF = CW'(RATIO / 2);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           phase_q <= '0;
    else if (!en_i)       phase_q <= '0;
    else if (mclk_rise_i) phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end

  assign fclk_o = en_i && (phase_q < HALF);
  assign tick_o = en_i && mclk_rise_i && (phase_q == LAST);

  // R5
  fgen_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !fclk_o);

endmodule

// File: rtl/clkratio_pwrseq.sv
module clkratio_pwrseq
  import clkratio_pkg::*;
#(
  parameter int unsigned MCLK_TMO    = 64,
  parameter int unsigned FCLK_TMO    = 4096,
  parameter int unsigned TOL         = 4,
  parameter int unsigned MUTE_FRAMES = 11265,
  parameter int unsigned PRE_CYCLES  = 127
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mclk_i,
  input  logic       fclk_i,
  input  logic       strap_master_i,
  output logic       fclk_o,
  output logic       fclk_oe_o,
  output logic [1:0] ratio_o,
  output logic [2:0] div_sel_o,
  output logic       ref_en_o,
  output logic       mute_o,
  output logic       mute_level_o,
  output logic       run_o
);
  localparam int unsigned CNT_W = $clog2(LARGEST_RATIO + TOL + 2) + 1;
  localparam int unsigned PW    = $clog2(PRE_CYCLES + 1);
  localparam int unsigned SW    = $clog2(MUTE_FRAMES + 1);
  localparam logic [PW-1:0] PRE_LAST    = PW'(PRE_CYCLES - 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(MUTE_FRAMES - 1);

  seq_state_t  state_q;
  ratio_code_t ratio_q;
  logic        decided_q, master_q;
  logic [PW-1:0] pre_q;
  logic [SW-1:0] settle_q;

  // named internal events
  logic mclk_rise, mclk_edge, mclk_alive;
  logic fclk_rise, fclk_edge, fclk_alive;
  logic gen_tick, frame_tick;
  logic meas_done;
  ratio_code_t meas_code;
  logic eff_master, clocks_ok, lost;
  logic gen_en;

  clk_presence #(.TMO(MCLK_TMO)) u_mclk_watch (
    .clk(clk), .rst_n(rst_n), .raw_i(mclk_i),
    .rise_o(mclk_rise), .edge_o(mclk_edge), .alive_o(mclk_alive)
  );

  clk_presence #(.TMO(FCLK_TMO)) u_fclk_watch (
    .clk(clk), .rst_n(rst_n), .raw_i(fclk_i),
    .rise_o(fclk_rise), .edge_o(fclk_edge), .alive_o(fclk_alive)
  );

  ratio_meter #(.TOL(TOL), .CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n),
    .clear_i(state_q != ST_MEAS),
    .mclk_rise_i(mclk_rise), .fclk_rise_i(fclk_rise),
    .done_o(meas_done), .code_o(meas_code)
  );

  frame_gen #(.RATIO(MASTER_DIV)) u_fgen (
    .clk(clk), .rst_n(rst_n), .en_i(gen_en), .mclk_rise_i(mclk_rise),
    .fclk_o(fclk_o), .tick_o(gen_tick)
  );

  assign eff_master = decided_q ? master_q : strap_master_i;
  assign clocks_ok  = mclk_alive && (eff_master || fclk_alive);
  assign lost       = !mclk_alive || (!master_q && !fclk_alive);
  assign frame_tick = master_q ? gen_tick : fclk_rise;

  // strap capture, once per reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decided_q <= 1'b0;
      master_q  <= 1'b0;
    end else if (mclk_alive && !decided_q) begin
      decided_q <= 1'b1;
      master_q  <= strap_master_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_OFF;
      ratio_q  <= RC_NONE;
      pre_q    <= '0;
      settle_q <= '0;
    end else if (state_q == ST_OFF) begin
      ratio_q  <= RC_NONE;
      pre_q    <= '0;
      settle_q <= '0;
      if (clocks_ok) begin
        if (eff_master) begin
          state_q <= ST_PRE;
          ratio_q <= RC_256;
        end else begin
          state_q <= ST_MEAS;
        end
      end
    end else if (lost) begin
      state_q <= ST_OFF;
      ratio_q <= RC_NONE;
    end else begin
      case (state_q)
        ST_PRE: begin
          if (mclk_rise) begin
            if (pre_q == PRE_LAST) state_q <= ST_SETTLE;
            else                   pre_q   <= pre_q + 1'b1;
          end
        end
        ST_MEAS: begin
          if (meas_done && (meas_code != RC_NONE)) begin
            ratio_q <= meas_code;
            state_q <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (frame_tick) begin
            if (settle_q == SETTLE_LAST) state_q  <= ST_RUN;
            else                         settle_q <= settle_q + 1'b1;
          end
        end
        ST_RUN:  state_q <= ST_RUN;
        default: state_q <= ST_OFF;
      endcase
    end
  end

  assign ref_en_o     = (state_q == ST_SETTLE) || (state_q == ST_RUN);
  assign gen_en       = master_q && ref_en_o;
  assign fclk_oe_o    = gen_en;
  assign run_o        = (state_q == ST_RUN);
  assign mute_o       = (state_q != ST_RUN);
  assign mute_level_o = ~eff_master;
  assign ratio_o      = ratio_q;
  assign div_sel_o    = code_to_sel(ratio_q);

  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decided_q |=> (decided_q && $stable(master_q)));

  // R9
  mclk_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_OFF && !mclk_alive) |=> (state_q == ST_OFF));

  // R3
  lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MEAS && !lost && meas_done && meas_code != RC_NONE)
      |=> (ratio_q == $past(meas_code)));

  // R5
  oe_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fclk_oe_o |-> master_q);

  // R6
  refen_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_en_o |-> ($onehot(div_sel_o) && ratio_q != RC_NONE));

  // R7
  run_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> $past(frame_tick));

  // R7
  settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settle_q <= SETTLE_LAST);

endmodule

// File: tb/tb_clkratio_pwrseq.sv
module tb_clkratio_pwrseq;
  localparam int unsigned MCLK_TMO    = 16;
  localparam int unsigned FCLK_TMO    = 1100;
  localparam int unsigned TOL         = 2;
  localparam int unsigned MUTE_FRAMES = 3;
  localparam int unsigned PRE_CYCLES  = 127;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclk_i = 1'b0;
  logic fclk_i = 1'b0;
  logic strap = 1'b1;
  logic fclk_o, fclk_oe_o, ref_en_o, mute_o, mute_level_o, run_o;
  logic [1:0] ratio_o;
  logic [2:0] div_sel_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  bit mclk_run = 0;
  bit fclk_run = 0;
  int ratio_n = 256;
  int mph = 0;
  int fcnt = 0;
  int mrise_total = 0;
  int frise_total = 0;

  clkratio_pwrseq #(
    .MCLK_TMO(MCLK_TMO), .FCLK_TMO(FCLK_TMO), .TOL(TOL),
    .MUTE_FRAMES(MUTE_FRAMES), .PRE_CYCLES(PRE_CYCLES)
  ) dut (
    .clk(clk), .rst_n(rst_n), .mclk_i(mclk_i), .fclk_i(fclk_i),
    .strap_master_i(strap), .fclk_o(fclk_o), .fclk_oe_o(fclk_oe_o),
    .ratio_o(ratio_o), .div_sel_o(div_sel_o), .ref_en_o(ref_en_o),
    .mute_o(mute_o), .mute_level_o(mute_level_o), .run_o(run_o)
  );

  initial forever #2 clk = ~clk;

  // clock stimulus: mclk period = 4 reference cycles, frame = ratio_n mclk periods
  initial begin
    forever begin
      @(negedge clk);
      if (mclk_run) begin
        mph = (mph + 1) % 4;
        if (mph == 2) begin
          mclk_i = 1'b1;
          mrise_total++;
        end
        if (mph == 0) begin
          mclk_i = 1'b0;
          fcnt = (fcnt + 1) % ratio_n;
          if (fclk_run) begin
            if ((fcnt < ratio_n / 2) && !fclk_i) frise_total++;
            fclk_i = (fcnt < ratio_n / 2);
          end
        end
      end
      if (!fclk_run) fclk_i = 1'b0;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_mrise(input int target);
    while (mrise_total < target) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wait_frise(input int target);
    while (frise_total < target) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    mclk_run = 0;
    fclk_run = 0;
    wait_clk(2);
    mph = 0;
    mclk_i = 1'b0;
    fclk_i = 1'b0;
    mrise_total = 0;
    frise_total = 0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
  endtask

  task automatic check_off(input string req);
    check(req, int'(mute_o), 1);
    check(req, int'(run_o), 0);
    check(req, int'(ref_en_o), 0);
    check(req, int'(fclk_oe_o), 0);
    check(req, int'(ratio_o), 0);
    check(req, int'(div_sel_o), 0);
  endtask

  initial begin
    longint t0, t1, t2;
    int base;

    // ---------------- master operation ----------------
    strap = 1'b1;
    do_reset();
    wait_clk(50);
    check_off("R1 idle without master clock");
    check("R8 level follows strap before capture", int'(mute_level_o), 0);

    mclk_run = 1;
    wait_mrise(PRE_CYCLES - 1);
    check("R5 frame clock not yet driven", int'(fclk_oe_o), 0);
    check("R6 reference still off", int'(ref_en_o), 0);
    wait_mrise(PRE_CYCLES + 3);
    check("R5 frame clock driven", int'(fclk_oe_o), 1);
    check("R6 reference with frame clock", int'(ref_en_o), 1);
    check("R5 master ratio code", int'(ratio_o), 1);
    check("R5 master divider select", int'(div_sel_o), 1);
    check("R7 muted at start of settle", int'(mute_o), 1);
    check("R8 master mute level", int'(mute_level_o), 0);

    @(posedge fclk_o); t0 = $time;
    @(negedge fclk_o); t1 = $time;
    @(posedge fclk_o); t2 = $time;
    check("R5 frame high time in ref cycles", int'((t1 - t0) / 4), 512);
    check("R5 frame period in ref cycles", int'((t2 - t0) / 4), 1024);

    wait_mrise(PRE_CYCLES + 1 + 256 * MUTE_FRAMES - 3);
    check("R7 still muted before interval ends", int'(mute_o), 1);
    wait_mrise(PRE_CYCLES + 1 + 256 * MUTE_FRAMES + 3);
    check("R7 mute released", int'(mute_o), 0);
    check("R7 run flag", int'(run_o), 1);

    strap = 1'b0;
    mclk_run = 0;
    wait_clk(MCLK_TMO + 10);
    check_off("R9 master clock loss");
    check("R2 strap change ignored (level)", int'(mute_level_o), 0);

    base = mrise_total;
    mclk_run = 1;
    wait_mrise(base + PRE_CYCLES + 3);
    check("R10 master restart drives frame clock", int'(fclk_oe_o), 1);
    check("R2 strap change ignored (still master)", int'(ref_en_o), 1);

    // ---------------- slave operation ----------------
    strap = 1'b0;
    do_reset();
    mclk_run = 1;
    wait_clk(300);
    check_off("R1 slave waits for frame clock");
    check("R8 slave mute level", int'(mute_level_o), 1);

    ratio_n = 258;
    fcnt = ratio_n - 1;
    fclk_run = 1;
    base = frise_total;
    wait_frise(base + 2);
    wait_clk(100);
    check("R3 no lock before a full frame", int'(ratio_o), 0);
    wait_frise(base + 3);
    wait_clk(20);
    check("R3 lock 258 as 256", int'(ratio_o), 1);
    check("R3 divider select 256", int'(div_sel_o), 1);
    check("R6 reference on after lock", int'(ref_en_o), 1);
    check("R7 muted after lock", int'(mute_o), 1);
    wait_frise(base + 2 + MUTE_FRAMES);
    wait_clk(20);
    check("R7 slave still muted", int'(mute_o), 1);
    wait_frise(base + 3 + MUTE_FRAMES);
    wait_clk(20);
    check("R7 slave mute released", int'(mute_o), 0);
    check("R7 slave run", int'(run_o), 1);
    check("R8 slave level held", int'(mute_level_o), 1);

    fclk_run = 0;
    wait_clk(FCLK_TMO + 30);
    check_off("R9 frame clock loss");

    ratio_n = 510;
    fcnt = ratio_n - 1;
    fclk_run = 1;
    base = frise_total;
    wait_frise(base + 2);
    wait_clk(100);
    check("R10 ratio cleared before new lock", int'(ratio_o), 0);
    wait_frise(base + 3);
    wait_clk(20);
    check("R10 remeasured 510 as 512", int'(ratio_o), 3);
    check("R3 divider select 512", int'(div_sel_o), 4);

    mclk_run = 0;
    wait_clk(MCLK_TMO + 10);
    check_off("R9 slave master clock loss");

    mclk_run = 1;
    fclk_run = 0;
    wait_clk(FCLK_TMO + 30);
    ratio_n = 381;
    fcnt = ratio_n - 1;
    fclk_run = 1;
    base = frise_total;
    wait_frise(base + 6);
    wait_clk(20);
    check("R4 381 rejected", int'(ratio_o), 0);
    check("R4 reference stays off", int'(ref_en_o), 0);
    check("R4 still muted", int'(mute_o), 1);

    ratio_n = 386;
    base = frise_total;
    wait_frise(base + 1);
    wait_clk(20);
    check("R4 retry locks 386 as 384", int'(ratio_o), 2);
    check("R3 divider select 384", int'(div_sel_o), 2);

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule